// File: doc/BRIEF.md
# Slow-Morse Multi-Mode Beacon Keyer

The keyer turns a stream of pre-encoded Morse elements into two control lines for a frequency synthesizer: a carrier enable and a high/low tone select. The synthesizer adds a small frequency offset when the tone select is high. The keyer supports four keying styles. Slow on/off keying (QRSS) and normal-speed CW both switch the carrier. Frequency-shift CW (FSKCW) keeps the carrier running and moves it down a few hertz during pauses. Dual-frequency CW (DFCW) sends dots and dashes with equal length and tells them apart by tone.

A message store upstream presents one element at a time on a valid/ready stream. The keyer raises `elem_ready` only while it is waiting. A transfer takes place on any clock edge where `elem_valid` and `elem_ready` are both high. After that edge `elem_ready` stays low until the element's mark and its trailing space have both run out. The source may hold `elem_valid` high for as long as it likes, and the element then waits without being consumed. For a looping beacon the source presents the end-of-message code after the last element. The keyer sends a word-length pause for that code, and the store then presents the first element again. All timing is counted from a 1 ms `tick` strobe.

Top module: `beacon_keyer`

## Requirements
- R1: After reset `elem_ready` is 1, and `carrier_on` and `tone_high` are both 0.
- R2: An element is consumed only on an edge where `elem_valid` and `elem_ready` are both high. From the next cycle `elem_ready` is 0 until the element's mark and space have finished, and it returns to 1 in the cycle after that. An element held on the stream during this time waits and is not lost.
- R3: One unit lasts N*TICKS_PER_SEC ticks in the three slow modes, where `speed_sel` 0, 1 and 2 give N = 3, 6 and 10 and code 3 is treated like 2. In CW mode one unit is CW_DOT_TICKS ticks (75, which is 16 wpm) whatever `speed_sel` is.
- R4: `mode_sel` 0 (QRSS). A dot (`elem_code` 0) is 1 unit of carrier followed by 1 unit without carrier. A dash (`elem_code` 1) is 3 units of carrier followed by 1 unit without carrier. `tone_high` stays 0.
- R5: `mode_sel` 3 (CW) uses the QRSS shapes with the fixed CW unit.
- R6: `mode_sel` 2 (FSKCW) uses the QRSS durations. The carrier stays on throughout, `tone_high` is 1 during marks and 0 during spaces.
- R7: `mode_sel` 1 (DFCW). A dot and a dash each give a 1-unit mark and then a 1-unit space, with the carrier on throughout. `tone_high` is 1 only during a dash mark.
- R8: Gap codes have no mark. Code 2 (letter gap) is 3 units of space. Codes 3 (word gap) and 4 (end of message) are 7 units of space. Codes 5 to 7 are handled as a word gap. During a space the carrier is on only in FSKCW and DFCW, and the tone is low.
- R9: `mode_sel` and `speed_sel` are sampled only when an element is consumed. Changing them during an element does not alter that element.
- R10: Durations count only cycles in which `tick` is 1. While `tick` is 0, outputs and progress are held.
- R11: While waiting for an element, `carrier_on` is 1 with `tone_high` 0 if the last consumed element was sent in FSKCW or DFCW. Otherwise both outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timing strobe, one cycle per ms |
| mode_sel | input | 2 | 0 QRSS, 1 DFCW, 2 FSKCW, 3 CW |
| speed_sel | input | 2 | Slow-mode speed code (3/6/10 s unit) |
| elem_valid | input | 1 | Element stream valid |
| elem_code | input | 3 | Element code (see R4, R8) |
| elem_ready | output | 1 | Keyer can accept an element |
| carrier_on | output | 1 | Synthesizer output enable |
| tone_high | output | 1 | Select the upper tone offset |

## Verification
The element is taken at the edge where valid and ready are both high. Its mark is visible from the very next cycle, or its space for a gap code. With a tick on every cycle, ready comes back exactly mark+space cycles later. The bench drives inputs on falling edges and, from the first falling edge after the transfer, counts the cycles until ready returns, adding up carrier-on and tone-high cycles on the way. Each element then has three exact counts. When ticks are withheld for K cycles the window is expected to grow by exactly K cycles. The waiting-state outputs are sampled on the falling edge where ready has returned.

// File: rtl/beacon_pkg.sv
package beacon_pkg;
  typedef enum logic [1:0] {
    MODE_QRSS  = 2'd0,
    MODE_DFCW  = 2'd1,
    MODE_FSKCW = 2'd2,
    MODE_CW    = 2'd3
  } key_mode_t;

  typedef enum logic [2:0] {
    EL_DOT  = 3'd0,
    EL_DASH = 3'd1,
    EL_LGAP = 3'd2,
    EL_WGAP = 3'd3,
    EL_END  = 3'd4
  } elem_t;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_MARK  = 2'd1,
    PH_SPACE = 2'd2
  } phase_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/beacon_unit_len.sv
module beacon_unit_len
  import beacon_pkg::*;
#(
  parameter int TICKS_PER_SEC = 1000,
  parameter int CW_DOT_TICKS  = 75,
  parameter int SPD0_SEC      = 3,
  parameter int SPD1_SEC      = 6,
  parameter int SPD2_SEC      = 10,
  parameter int LEN_W         = 14
) (
  input  key_mode_t        mode,
  input  logic [1:0]       speed,
  output logic [LEN_W-1:0] unit_len
);
  logic [LEN_W-1:0] slow_len [4];

  // speed code 3 falls back to the slowest setting
  for (genvar g = 0; g < 4; g++) begin : g_spd
    localparam int SECS = (g == 0) ? SPD0_SEC : (g == 1) ? SPD1_SEC : SPD2_SEC;
    assign slow_len[g] = LEN_W'(SECS * TICKS_PER_SEC);
  end

  assign unit_len = (mode == MODE_CW) ? LEN_W'(CW_DOT_TICKS) : slow_len[speed];
endmodule

// File: rtl/beacon_plan.sv
module beacon_plan
  import beacon_pkg::*;
(
  input  key_mode_t  mode,
  input  logic [2:0] code,
  output logic [2:0] mark_units,
  output logic [2:0] space_units
);
  always_comb begin
    mark_units  = 3'd0;
    space_units = 3'd7;
    case (code)
      EL_DOT: begin
        mark_units  = 3'd1;
        space_units = 3'd1;
      end
      EL_DASH: begin
        mark_units  = (mode == MODE_DFCW) ? 3'd1 : 3'd3;
        space_units = 3'd1;
      end
      EL_LGAP: space_units = 3'd3;
      default: space_units = 3'd7;
    endcase
  end
endmodule

// File: rtl/beacon_drive.sv
module beacon_drive
  import beacon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  phase_t     phase,
  input  key_mode_t  cur_mode,
  input  logic [2:0] cur_code,
  output logic       carrier_on,
  output logic       tone_high
);
  logic continuous;
  assign continuous = (cur_mode == MODE_DFCW) || (cur_mode == MODE_FSKCW);

  always_comb begin
    carrier_on = continuous;
    tone_high  = 1'b0;
    if (phase == PH_MARK) begin
      carrier_on = 1'b1;
      case (cur_mode)
        MODE_FSKCW: tone_high = 1'b1;
        MODE_DFCW:  tone_high = (cur_code == EL_DASH);
        default:    tone_high = 1'b0;
      endcase
    end
  end

  // R4
  onoff_tone_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_mode == MODE_QRSS || cur_mode == MODE_CW) |-> !tone_high);

  // R6
  cont_carrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cur_mode == MODE_FSKCW || cur_mode == MODE_DFCW) && phase != PH_IDLE) |-> carrier_on);
endmodule

// File: rtl/beacon_seq.sv
module beacon_seq
  import beacon_pkg::*;
#(
  parameter int LEN_W = 14,
  parameter int CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  key_mode_t        mode_in,
  input  logic [2:0]       code_in,
  input  logic [LEN_W-1:0] unit_in,
  input  logic [2:0]       mark_units_in,
  input  logic [2:0]       space_units_in,
  input  logic             elem_valid,
  output logic             elem_ready,
  output phase_t           phase,
  output key_mode_t        cur_mode,
  output logic [2:0]       cur_code
);
  logic [CNT_W-1:0] cnt, mark_len, space_len, mark_next, space_next;
  logic [LEN_W-1:0] cur_unit;
  logic             accept;

  assign mark_next  = {3'b000, unit_in} * {{LEN_W{1'b0}}, mark_units_in};
  assign space_next = {3'b000, unit_in} * {{LEN_W{1'b0}}, space_units_in};
  assign elem_ready = (phase == PH_IDLE);
  assign accept     = elem_ready && elem_valid;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      cnt       <= '0;
      cur_mode  <= MODE_QRSS;
      cur_code  <= 3'd0;
      cur_unit  <= '0;
      mark_len  <= '0;
      space_len <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (elem_valid) begin
          cur_mode  <= mode_in;
          cur_code  <= code_in;
          cur_unit  <= unit_in;
          mark_len  <= mark_next;
          space_len <= space_next;
          cnt       <= '0;
          phase     <= (mark_units_in != 3'd0) ? PH_MARK : PH_SPACE;
        end
        PH_MARK: if (tick) begin
          if (cnt == mark_len - CNT_W'(1)) begin
            cnt   <= '0;
            phase <= PH_SPACE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        PH_SPACE: if (tick) begin
          if (cnt == space_len - CNT_W'(1)) begin
            cnt   <= '0;
            phase <= PH_IDLE;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R2
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !elem_ready);

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE && $past(phase) != PH_IDLE) |-> ($stable(cur_mode) && $stable(cur_unit)));

  // R10
  no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && phase != PH_IDLE) |=> ($stable(cnt) && $stable(phase)));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_MARK) |-> (cnt < mark_len));
endmodule

// File: rtl/beacon_keyer.sv
module beacon_keyer
  import beacon_pkg::*;
#(
  parameter int TICKS_PER_SEC = 1000,
  parameter int CW_DOT_TICKS  = 75,
  parameter int SPD0_SEC      = 3,
  parameter int SPD1_SEC      = 6,
  parameter int SPD2_SEC      = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic [1:0] mode_sel,
  input  logic [1:0] speed_sel,
  input  logic       elem_valid,
  input  logic [2:0] elem_code,
  output logic       elem_ready,
  output logic       carrier_on,
  output logic       tone_high
);
  localparam int MAX_SLOW = imax(imax(SPD0_SEC, SPD1_SEC), SPD2_SEC) * TICKS_PER_SEC;
  localparam int MAX_UNIT = imax(MAX_SLOW, CW_DOT_TICKS);
  localparam int LEN_W    = $clog2(MAX_UNIT + 1);
  localparam int CNT_W    = LEN_W + 3;

  key_mode_t        mode_live, cur_mode;
  logic [LEN_W-1:0] unit_len;
  logic [2:0]       mark_units, space_units, cur_code;
  phase_t           phase;

  assign mode_live = key_mode_t'(mode_sel);

  beacon_unit_len #(
    .TICKS_PER_SEC(TICKS_PER_SEC), .CW_DOT_TICKS(CW_DOT_TICKS),
    .SPD0_SEC(SPD0_SEC), .SPD1_SEC(SPD1_SEC), .SPD2_SEC(SPD2_SEC), .LEN_W(LEN_W)
  ) u_len (
    .mode(mode_live), .speed(speed_sel), .unit_len(unit_len)
  );

  beacon_plan u_plan (
    .mode(mode_live), .code(elem_code),
    .mark_units(mark_units), .space_units(space_units)
  );

  beacon_seq #(.LEN_W(LEN_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .mode_in(mode_live), .code_in(elem_code), .unit_in(unit_len),
    .mark_units_in(mark_units), .space_units_in(space_units),
    .elem_valid(elem_valid), .elem_ready(elem_ready),
    .phase(phase), .cur_mode(cur_mode), .cur_code(cur_code)
  );

  beacon_drive u_drive (
    .clk(clk), .rst_n(rst_n), .phase(phase), .cur_mode(cur_mode),
    .cur_code(cur_code), .carrier_on(carrier_on), .tone_high(tone_high)
  );

  // R11
  idle_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (elem_ready && (cur_mode == MODE_QRSS || cur_mode == MODE_CW)) |-> (!carrier_on && !tone_high));
endmodule

// File: tb/beacon_keyer_tb_top.sv
module beacon_keyer_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic [1:0] mode_sel = 2'd0;
  logic [1:0] speed_sel = 2'd0;
  logic       elem_valid = 1'b0;
  logic [2:0] elem_code = 3'd0;
  logic       elem_ready, carrier_on, tone_high;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  beacon_keyer #(.TICKS_PER_SEC(1), .CW_DOT_TICKS(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode_sel(mode_sel),
    .speed_sel(speed_sel), .elem_valid(elem_valid), .elem_code(elem_code),
    .elem_ready(elem_ready), .carrier_on(carrier_on), .tone_high(tone_high)
  );

  // {mode, speed, code, window cycles, carrier-on cycles, tone-high cycles}
  // tick every cycle; slow units 3/6/10/10 cycles, CW unit 2 cycles
  localparam int NV = 15;
  localparam int VEC [NV][6] = '{
    '{0, 0, 0,  6,  3, 0},
    '{0, 0, 1, 12,  9, 0},
    '{0, 1, 2, 18,  0, 0},
    '{2, 0, 0,  6,  6, 3},
    '{2, 0, 1, 12, 12, 9},
    '{2, 0, 3, 21, 21, 0},
    '{1, 0, 0,  6,  6, 0},
    '{1, 0, 1,  6,  6, 3},
    '{1, 2, 2, 30, 30, 0},
    '{3, 2, 0,  4,  2, 0},
    '{3, 0, 1,  8,  6, 0},
    '{0, 3, 0, 20, 10, 0},
    '{0, 0, 4, 21,  0, 0},
    '{1, 1, 1, 12, 12, 6},
    '{0, 0, 6, 21,  0, 0}
  };

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic string tag_of(input int m, input int c);
    if (c >= 2) return "R8";
    case (m)
      0: return "R4";
      1: return "R7";
      2: return "R6";
      default: return "R5";
    endcase
  endfunction

  // Call just before the accepting edge. Counts cycles until ready returns.
  task automatic measure(input bit keep_valid, input int freeze_at, input int chg_at,
                         output int t, output int on_c, output int hi_c);
    @(posedge clk);
    @(negedge clk);
    if (!keep_valid) elem_valid = 1'b0;
    t = 0; on_c = 0; hi_c = 0;
    while (!elem_ready && t < 500) begin
      t++;
      on_c += int'(carrier_on);
      hi_c += int'(tone_high);
      tick = !(freeze_at > 0 && t >= freeze_at && t < freeze_at + 20);
      if (chg_at > 0 && t == chg_at) begin
        mode_sel = 2'd2;
        speed_sel = 2'd2;
      end
      @(negedge clk);
    end
    tick = 1'b1;
  endtask

  task automatic present(input int m, input int s, input int c);
    @(negedge clk);
    mode_sel = m[1:0]; speed_sel = s[1:0]; elem_code = c[2:0]; elem_valid = 1'b1;
    while (!elem_ready) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int t, on_c, hi_c;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ready", int'(elem_ready), 1);
    check("R1 carrier", int'(carrier_on), 0);
    check("R1 tone", int'(tone_high), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      present(VEC[i][0], VEC[i][1], VEC[i][2]);
      measure(1'b0, 0, 0, t, on_c, hi_c);
      check({tag_of(VEC[i][0], VEC[i][2]), " R3 window"}, t, VEC[i][3]);
      check({tag_of(VEC[i][0], VEC[i][2]), " carrier"}, on_c, VEC[i][4]);
      check({tag_of(VEC[i][0], VEC[i][2]), " tone"}, hi_c, VEC[i][5]);
    end

    // R9: QRSS speed-3 dash, mode/speed changed mid element
    present(0, 0, 1);
    measure(1'b0, 0, 2, t, on_c, hi_c);
    check("R9 window", t, 12);
    check("R9 carrier", on_c, 9);
    check("R9 tone", hi_c, 0);
    // R11: waiting after QRSS element is dark
    check("R11 dark idle", int'(carrier_on), 0);

    // R11: waiting after FSKCW element keeps low-tone carrier
    present(2, 0, 0);
    measure(1'b0, 0, 0, t, on_c, hi_c);
    check("R11 idle carrier", int'(carrier_on), 1);
    check("R11 idle tone", int'(tone_high), 0);

    // R10: 20 cycles without tick stretch a QRSS dash by 20
    present(0, 0, 1);
    measure(1'b0, 5, 0, t, on_c, hi_c);
    check("R10 window", t, 32);
    check("R10 carrier", on_c, 29);

    // R2: valid held through a busy dot; same dot taken again afterwards
    present(0, 0, 0);
    measure(1'b1, 0, 0, t, on_c, hi_c);
    check("R2 first window", t, 6);
    check("R2 ready back", int'(elem_ready), 1);
    measure(1'b0, 0, 0, t, on_c, hi_c);
    check("R2 held element window", t, 6);
    check("R2 held element carrier", on_c, 3);

    repeat (2) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule